// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block produces the column addresses of a single SDRAM read or write burst, one column per beat. A controller presents a 4-bit mode word, which holds the burst-length code and the ordering bit. It also presents a 9-bit starting column and pulses `start`. From then on, each pulse of `advance` steps the sequencer to the next column.

For fixed burst lengths, the columns stay inside an aligned block whose size equals the burst length. The column bits above the block offset never change, and the offset wraps inside the block in either sequential or interleaved order. A full-page burst walks the whole 512-column page and wraps from the top back to zero. It continues until the controller asserts `terminate`. Mode codes that are reserved, or that cannot be combined, are refused at start and reported on an error flag.

Top module: `sdram_burst_colgen`

## Requirements
- R1: During and immediately after reset, `valid`, `last` and `mode_err` are 0.
- R2: The mode word is decoded as follows. Bits 2:0 select the burst length: 000 gives 1, 001 gives 2, 010 gives 4, 011 gives 8 and 111 gives a full page. Bit 3 selects the order: 0 is sequential and 1 is interleaved. A full page is legal only when bit 3 is 0.
- R3: Suppose `start` is sampled high at a clock edge with a legal mode. After that edge, `valid` is 1 and `col` equals the sampled `start_col`.
- R4: During a fixed-length burst of length BL, the column bits above log2(BL) keep their starting value on every beat.
- R5: In sequential order, the offset inside the block is the starting offset plus the beat number, modulo BL.
- R6: In interleaved order, the offset inside the block is the starting offset XOR the beat number.
- R7: `last` is 1 exactly on beat BL-1 of a fixed-length burst. A burst of length 1 is last on its first beat. An `advance` while `last` is 1 clears `valid`.
- R8: A full-page burst steps the column by one per `advance`, modulo 512, so that 511 is followed by 0. `last` is never 1 during a full-page burst.
- R9: `terminate` clears `valid` at the next edge. When `start` and `terminate` arrive together, `start` wins.
- R10: A `start` with a reserved code (100, 101 or 110, or 111 with bit 3 set) is ignored and sets `mode_err`. A running burst is left unchanged by such a start. The next legal `start` clears `mode_err`.
- R11: The mode word and ordering are captured at `start`. Changing `mode_word` during a burst has no effect. An `advance` while `valid` is 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_word | input | 4 | Burst-length code (bits 2:0) and order bit (bit 3) |
| start | input | 1 | Begin a burst at `start_col` |
| start_col | input | 9 | Starting column |
| advance | input | 1 | Step to the next beat |
| terminate | input | 1 | End the current burst |
| col | output | 9 | Current column |
| valid | output | 1 | A burst is in progress and `col` is meaningful |
| last | output | 1 | Current beat is the final beat of a fixed-length burst |
| mode_err | output | 1 | Last start attempt used an illegal mode |

## Verification
The assertions check several rules on every cycle:
- the upper column bits stay fixed while a burst advances;
- sequential steps add one inside the block;
- a full-page burst never raises `last`;
- `terminate` and a final `advance` end the burst;
- a refused start leaves the sequencer idle with `mode_err` set.

The exact column orders can only be shown by the bench's table of bursts: the interleaved patterns, wrap points and alignment at several starting offsets. The same holds for the 511-to-0 full-page wrap, the priority of `start` over `terminate`, and the fact that mode changes made mid-burst are ignored.

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen #(
  parameter int COL_W  = 9,
  parameter int MODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_word,
  input  logic              start,
  input  logic [COL_W-1:0]  start_col,
  input  logic              advance,
  input  logic              terminate,
  output logic [COL_W-1:0]  col,
  output logic              valid,
  output logic              last,
  output logic              mode_err
);

  localparam logic [COL_W-1:0] PAGE_MASK = {COL_W{1'b1}};

  logic [2:0]       len_code;
  logic             ilv_req;
  logic [COL_W-1:0] mask_dec;
  logic             fp_dec;
  logic             legal;

  logic             busy;
  logic [COL_W-1:0] base;
  logic [COL_W-1:0] beat;
  logic [COL_W-1:0] r_mask;
  logic             r_ilv;
  logic             r_fp;
  logic             err_q;

  assign len_code = mode_word[2:0];
  assign ilv_req  = mode_word[3];

  always_comb begin
    mask_dec = '0;
    fp_dec   = 1'b0;
    legal    = 1'b1;
    case (len_code)
      3'b000: mask_dec = COL_W'(0);
      3'b001: mask_dec = COL_W'(1);
      3'b010: mask_dec = COL_W'(3);
      3'b011: mask_dec = COL_W'(7);
      3'b111: begin
        mask_dec = PAGE_MASK;
        fp_dec   = 1'b1;
        legal    = !ilv_req;
      end
      default: legal = 1'b0;
    endcase
  end

  logic [COL_W-1:0] low_seq, low_int;
  assign low_seq = (base + beat) & r_mask;
  assign low_int = (base ^ beat) & r_mask;
  assign col     = (base & ~r_mask) | (r_ilv ? low_int : low_seq);

  assign valid    = busy;
  assign last     = busy && !r_fp && (beat == r_mask);
  assign mode_err = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      base   <= '0;
      beat   <= '0;
      r_mask <= '0;
      r_ilv  <= 1'b0;
      r_fp   <= 1'b0;
      err_q  <= 1'b0;
    end else if (start && legal) begin
      busy   <= 1'b1;
      base   <= start_col;
      beat   <= '0;
      r_mask <= mask_dec;
      r_ilv  <= ilv_req;
      r_fp   <= fp_dec;
      err_q  <= 1'b0;
    end else begin
      if (start) err_q <= 1'b1;
      if (terminate) begin
        busy <= 1'b0;
      end else if (advance && busy) begin
        if (last) busy <= 1'b0;
        else      beat <= beat + 1'b1;
      end
    end
  end

  assert_start_col_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start && legal |=> valid && (col == $past(start_col)));

  assert_block_fixed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    valid && advance && !last && !terminate && !start
      |=> valid && (((col ^ $past(col)) & ~$past(r_mask)) == '0));

  assert_seq_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !r_ilv && advance && !last && !terminate && !start
      |=> (((col - $past(col)) & $past(r_mask)) == COL_W'(1)));

  assert_last_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    last |-> valid);

  assert_last_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
    last && advance && !start && !terminate |=> !valid);

  assert_fp_no_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    valid && r_fp |-> !last);

  assert_term_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
    terminate && !start |=> !valid);

  assert_reserved_refused_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start && !legal && !valid |=> !valid && mode_err);

endmodule

// File: tb/tb_sdram_burst_colgen.sv
module tb_sdram_burst_colgen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] mode_word = '0;
  logic       start = 1'b0;
  logic [8:0] start_col = '0;
  logic       advance = 1'b0;
  logic       terminate = 1'b0;
  logic [8:0] col;
  logic       valid, last, mode_err;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  sdram_burst_colgen dut (
    .clk(clk), .rst_n(rst_n), .mode_word(mode_word), .start(start),
    .start_col(start_col), .advance(advance), .terminate(terminate),
    .col(col), .valid(valid), .last(last), .mode_err(mode_err)
  );

  // {mode[3:0], start[8:0], beats[3:0], expected columns 8 x 9 bits}
  localparam int NV = 8;
  localparam logic [88:0] VEC [NV] = '{
    {4'b0011, 9'd173, 4'd8, 9'd173, 9'd174, 9'd175, 9'd168, 9'd169, 9'd170, 9'd171, 9'd172},
    {4'b1011, 9'd173, 4'd8, 9'd173, 9'd172, 9'd175, 9'd174, 9'd169, 9'd168, 9'd171, 9'd170},
    {4'b0010, 9'd175, 4'd4, 9'd175, 9'd172, 9'd173, 9'd174, 9'd0, 9'd0, 9'd0, 9'd0},
    {4'b1010, 9'd175, 4'd4, 9'd175, 9'd174, 9'd173, 9'd172, 9'd0, 9'd0, 9'd0, 9'd0},
    {4'b0001, 9'd511, 4'd2, 9'd511, 9'd510, 9'd0, 9'd0, 9'd0, 9'd0, 9'd0, 9'd0},
    {4'b1001, 9'd64,  4'd2, 9'd64, 9'd65, 9'd0, 9'd0, 9'd0, 9'd0, 9'd0, 9'd0},
    {4'b0000, 9'd291, 4'd1, 9'd291, 9'd0, 9'd0, 9'd0, 9'd0, 9'd0, 9'd0, 9'd0},
    {4'b1011, 9'd6,   4'd8, 9'd6, 9'd7, 9'd4, 9'd5, 9'd2, 9'd3, 9'd0, 9'd1}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic idle();
    start = 0; advance = 0; terminate = 0;
  endtask

  task automatic begin_burst(input logic [3:0] m, input logic [8:0] c);
    mode_word = m; start_col = c; start = 1; advance = 0; terminate = 0;
    step();
    start = 0;
  endtask

  initial begin
    #4000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    step(); step();
    check("R1 valid in reset", valid, 0);
    check("R1 last in reset", last, 0);
    rst_n = 1;
    step();
    check("R1 valid after reset", valid, 0);
    check("R1 err after reset", mode_err, 0);

    // table walk: R2 R3 R4 R5 R6 R7
    for (int v = 0; v < NV; v++) begin
      int nb;
      nb = int'(VEC[v][75:72]);
      begin_burst(VEC[v][88:85], VEC[v][84:76]);
      for (int b = 0; b < nb; b++) begin
        check("R3/R4/R5/R6 column", col, int'(VEC[v][71-9*b -: 9]));
        check("R7 last flag", last, (b == nb - 1) ? 1 : 0);
        check("R3 valid", valid, 1);
        advance = 1;
        step();
        advance = 0;
      end
      check("R7 ended after last", valid, 0);
    end

    // R8 full page wrap, then R9 terminate
    begin_burst(4'b0111, 9'd509);
    for (int b = 0; b < 5; b++) begin
      check("R8 full page column", col, (509 + b) % 512);
      check("R8 no last", last, 0);
      advance = 1; step(); advance = 0;
    end
    terminate = 1; step(); idle();
    check("R9 terminate", valid, 0);

    // R10 reserved codes
    begin_burst(4'b0100, 9'd12);
    check("R10 reserved ignored", valid, 0);
    check("R10 err set", mode_err, 1);
    begin_burst(4'b1111, 9'd12);
    check("R10 full page interleaved refused", valid, 0);
    begin_burst(4'b0011, 9'd40);
    check("R10 err cleared", mode_err, 0);
    advance = 1; step(); advance = 0;
    begin_burst(4'b0110, 9'd300);
    check("R10 running burst kept", col, 41);
    check("R10 err on busy", mode_err, 1);

    // R11 mode change mid burst
    mode_word = 4'b1000;
    advance = 1; step(); advance = 0;
    check("R11 mode latched", col, 42);
    check("R11 still valid", valid, 1);
    terminate = 1; step(); idle();

    // R11 advance while idle
    advance = 1; step(); step(); advance = 0;
    check("R11 idle advance", valid, 0);

    // R9 start wins over terminate
    mode_word = 4'b0010; start_col = 9'd9; start = 1; terminate = 1;
    step(); idle();
    check("R9 start priority valid", valid, 1);
    check("R9 start priority col", col, 9);
    // R2 length 4 ends on fourth beat
    for (int b = 0; b < 3; b++) begin advance = 1; step(); end
    advance = 0;
    check("R2 len4 last", last, 1);
    check("R2 len4 col", col, 8);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule